// File: doc/BRIEF.md
# Serial Slave Port for Byte Register Access

This block lets an external host reach a 256-location, byte-wide register space over a four-wire synchronous serial link. The link has an active-low select, a shift clock, a data input and a data output. A level input picks the direction of each transfer. A wait output shows the host when an internal access is still in flight. Every transfer starts with one address byte. Data bytes follow it, and each byte moves least significant bit first. On the inside, the block drives a simple register-file port with an address, write data, a write strobe and a read strobe.

All serial inputs are brought into the system clock domain through a synchronizer chain. Shift-clock edges are found by comparing consecutive synchronized samples. Input bits are taken on rising shift-clock edges and output bits change after falling ones. A burst steps through consecutive locations and wraps from the top of the space back to zero. Read data is fetched ahead of need, so the first data bit is ready on the falling edge that follows the address byte.

Top module: `slink_serial_port`

## Requirements
- R1: While the select input is high, the output enable stays low and shift-clock activity causes no register-file strobe and no change to the transfer state.
- R2: The first byte shifted in after the select falls is taken as the register address, with the first bit received being bit 0.
- R3: When the direction input is low, each complete byte after the address is written: rf_we pulses for one clock with rf_wdata holding the byte (first received bit in bit 0) and rf_addr holding the target location; rf_we and rf_re are never high together.
- R4: Within one selected transfer, each data byte targets the location one above the previous byte, and location 0xFF is followed by 0x00.
- R5: When the direction input is high, rf_re pulses once the address byte completes and again after every data byte, for the next location. The byte fetched is sent least significant bit first, and each bit changes after a falling shift-clock edge. The output enable is high while select is low and the direction input is high.
- R6: When the direction input is low, the output enable is low and the data output is 0.
- R7: The wait output is high during every register-file strobe cycle. A write keeps it high for exactly one clock, and a read keeps it high for two clocks: the strobe cycle and the capture cycle that follows. It is low otherwise.
- R8: Raising the select in the middle of a byte discards the partial byte and resets the bit count, so the next transfer is decoded from its first bit.
- R9: After reset the output enable, the data output, the wait output and both strobes are low.
- R10: Read data is taken from rf_rdata in the clock cycle that follows the rf_re pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic and the synchronizers run on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the host |
| sck | input | 1 | Shift clock from the host, idle low |
| sdi | input | 1 | Serial data from the host |
| rd_nwr | input | 1 | Direction: 1 for read, 0 for write |
| sdo | output | 1 | Serial data to the host, valid while sdo_oe is high |
| sdo_oe | output | 1 | Output enable for the external serial-out driver |
| acc_wait | output | 1 | High while an internal register access is in progress |
| rf_addr | output | 8 | Register-file address |
| rf_wdata | output | 8 | Register-file write data |
| rf_we | output | 1 | Register-file write strobe, one clock |
| rf_re | output | 1 | Register-file read strobe, one clock |
| rf_rdata | input | 8 | Register-file read data, valid the cycle after rf_re |

## Verification
The assertions rely on four conditions that the host and the register file meet. The direction input stays constant for the whole of each selected transfer. The select changes only while the shift clock is low. Each shift-clock phase lasts long enough to cover the synchronizer delay and one read with its capture. The register file returns data one cycle after the read strobe. The stimulus sets direction before it lowers select and moves select only with the shift clock low. It holds each phase for eight system clocks and uses a register-file model with exactly that one-cycle read latency. Random bursts, wrap-around, aborted bytes and unselected clocking all stay inside those rules.

// File: rtl/slink_pkg.sv
package slink_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W);

    typedef struct packed {
        logic              sck_prev;
        logic [CNT_W-1:0]  bit_cnt;
        logic              expect_addr;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] rf_addr;
        logic [BYTE_W-1:0] wdata;
        logic [BYTE_W-1:0] tx;
        logic              sdo;
        logic              we;
        logic              re;
        logic              cap;
        logic              busy;
    } link_state_t;

endpackage

// File: rtl/slink_sync.sv
module slink_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (s == 0) begin : g_first
            assign stage_d = din;
        end else begin : g_next
            assign stage_d = stage_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/slink_core.sv
module slink_core
    import slink_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sck_s,
    input  logic              sdi_s,
    input  logic              rw_s,
    input  logic [BYTE_W-1:0] rf_rdata,
    output logic [BYTE_W-1:0] rf_addr,
    output logic [BYTE_W-1:0] rf_wdata,
    output logic              rf_we,
    output logic              rf_re,
    output logic              sdo_bit,
    output logic              acc_wait
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    link_state_t st_d, st_q;

    always_comb begin
        logic              rise;
        logic              fall;
        logic [BYTE_W-1:0] byte_in;

        st_d          = st_q;
        st_d.we       = 1'b0;
        st_d.re       = 1'b0;
        st_d.cap      = st_q.re;
        st_d.sck_prev = sck_s;

        rise    = sck_s & ~st_q.sck_prev;
        fall    = ~sck_s & st_q.sck_prev;
        byte_in = {sdi_s, st_q.rx[BYTE_W-1:1]};

        // data requested in the previous cycle is on rf_rdata now
        if (st_q.cap) begin
            st_d.tx = rf_rdata;
        end

        if (cs_s) begin
            st_d.bit_cnt     = '0;
            st_d.expect_addr = 1'b1;
            st_d.rx          = '0;
        end else if (rise) begin
            st_d.rx      = byte_in;
            st_d.bit_cnt = st_q.bit_cnt + 1'b1;
            if (st_q.bit_cnt == LAST_BIT) begin
                if (st_q.expect_addr) begin
                    st_d.expect_addr = 1'b0;
                    st_d.addr        = byte_in;
                    st_d.rf_addr     = byte_in;
                    st_d.re          = rw_s;
                end else if (rw_s) begin
                    st_d.addr    = st_q.addr + 1'b1;
                    st_d.rf_addr = st_q.addr + 1'b1;
                    st_d.re      = 1'b1;
                end else begin
                    st_d.rf_addr = st_q.addr;
                    st_d.addr    = st_q.addr + 1'b1;
                    st_d.wdata   = byte_in;
                    st_d.we      = 1'b1;
                end
            end
        end else if (fall && rw_s) begin
            st_d.sdo = st_q.tx[st_q.bit_cnt];
        end

        st_d.busy = st_d.we | st_d.re | st_d.cap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q             <= '0;
            st_q.expect_addr <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rf_addr  = st_q.rf_addr;
    assign rf_wdata = st_q.wdata;
    assign rf_we    = st_q.we;
    assign rf_re    = st_q.re;
    assign sdo_bit  = st_q.sdo;
    assign acc_wait = st_q.busy;

endmodule

// File: rtl/slink_serial_port.sv
module slink_serial_port #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       sdi,
    input  logic       rd_nwr,
    output logic       sdo,
    output logic       sdo_oe,
    output logic       acc_wait,
    output logic [7:0] rf_addr,
    output logic [7:0] rf_wdata,
    output logic       rf_we,
    output logic       rf_re,
    input  logic [7:0] rf_rdata
);

    localparam int unsigned N_IN = 4;

    logic [N_IN-1:0] pins_s;
    logic cs_s, sck_s, sdi_s, rw_s;
    logic sdo_bit;

    slink_sync #(
        .WIDTH  (N_IN),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1000)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sck, sdi, rd_nwr}),
        .dout (pins_s)
    );

    assign {cs_s, sck_s, sdi_s, rw_s} = pins_s;

    slink_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (cs_s),
        .sck_s   (sck_s),
        .sdi_s   (sdi_s),
        .rw_s    (rw_s),
        .rf_rdata(rf_rdata),
        .rf_addr (rf_addr),
        .rf_wdata(rf_wdata),
        .rf_we   (rf_we),
        .rf_re   (rf_re),
        .sdo_bit (sdo_bit),
        .acc_wait(acc_wait)
    );

    assign sdo_oe = ~cs_s & rw_s;
    assign sdo    = sdo_oe & sdo_bit;

endmodule

// File: rtl/slink_serial_port_chk.sv
module slink_serial_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_s,
    input logic       sdo_oe,
    input logic       acc_wait,
    input logic [7:0] rf_addr,
    input logic       rf_we,
    input logic       rf_re
);

    logic       wr_seen_q, rd_seen_q;
    logic [7:0] wr_last_q, rd_last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_seen_q <= 1'b0;
            rd_seen_q <= 1'b0;
            wr_last_q <= '0;
            rd_last_q <= '0;
        end else if (cs_s) begin
            wr_seen_q <= 1'b0;
            rd_seen_q <= 1'b0;
        end else begin
            if (rf_we) begin
                wr_seen_q <= 1'b1;
                wr_last_q <= rf_addr;
            end
            if (rf_re) begin
                rd_seen_q <= 1'b1;
                rd_last_q <= rf_addr;
            end
        end
    end

    // R1
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> !(rf_we || rf_re));

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && rf_re));

    // R6
    write_quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !sdo_oe);

    // R7
    strobe_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || rf_re) |-> acc_wait);

    // R7
    read_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rf_re) |-> acc_wait);

    // R4
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && wr_seen_q) |-> rf_addr == 8'(wr_last_q + 8'd1));

    // R4
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_re && rd_seen_q) |-> rf_addr == 8'(rd_last_q + 8'd1));

endmodule

bind slink_serial_port slink_serial_port_chk chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (cs_s),
    .sdo_oe  (sdo_oe),
    .acc_wait(acc_wait),
    .rf_addr (rf_addr),
    .rf_we   (rf_we),
    .rf_re   (rf_re)
);

// File: tb/slink_serial_port_test.sv
module slink_serial_port_test;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, rd_nwr = 1'b0;
    logic       sdo, sdo_oe, acc_wait, rf_we, rf_re;
    logic [7:0] rf_addr, rf_wdata;
    logic [7:0] rf_rdata = '0;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    int checks = 0, errors = 0;
    int we_cnt = 0, re_cnt = 0, wait_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    slink_serial_port uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .rd_nwr(rd_nwr), .sdo(sdo), .sdo_oe(sdo_oe), .acc_wait(acc_wait),
        .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_re(rf_re),
        .rf_rdata(rf_rdata)
    );

    // register file model: one-cycle read latency
    always @(posedge clk) begin
        if (rf_we) mem[rf_addr] <= rf_wdata;
        if (rf_re) rf_rdata <= mem[rf_addr];
        if (rf_we) we_cnt <= we_cnt + 1;
        if (rf_re) re_cnt <= re_cnt + 1;
        if (acc_wait) wait_cnt <= wait_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic clk_bit(input logic b, output logic got);
        sdi = b;
        repeat (HALF) @(negedge clk);
        got = sdo;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic xfer_byte(input logic [7:0] v, output logic [7:0] got);
        for (int i = 0; i < 8; i++) begin
            logic g;
            clk_bit(v[i], g);
            got[i] = g;
        end
    endtask

    task automatic begin_txn(input logic rd);
        rd_nwr = rd;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic end_txn();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic write_burst(input logic [7:0] a, input int n);
        logic [7:0] g;
        begin_txn(1'b0);
        xfer_byte(a, g);
        for (int k = 0; k < n; k++) begin
            logic [7:0] v;
            v = 8'($urandom);
            xfer_byte(v, g);
            exp_mem[8'(a + k)] = v;
        end
        check(sdo_oe == 1'b0, "R6", sdo_oe, 0);
        end_txn();
    endtask

    task automatic read_burst(input logic [7:0] a, input int n, input string req);
        logic [7:0] g;
        begin_txn(1'b1);
        xfer_byte(a, g);
        check(sdo_oe == 1'b1, "R5", sdo_oe, 1);
        for (int k = 0; k < n; k++) begin
            xfer_byte(8'($urandom), g);
            check(g == exp_mem[8'(a + k)], req, g, exp_mem[8'(a + k)]);
        end
        end_txn();
    endtask

    initial begin
        logic [7:0] g;
        int w0, r0, t0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i ^ 8'h5A);
            exp_mem[i] = 8'(i ^ 8'h5A);
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9 reset state
        check(sdo_oe == 0 && sdo == 0, "R9", {sdo_oe, sdo}, 0);
        check(acc_wait == 0 && rf_we == 0 && rf_re == 0, "R9",
              {acc_wait, rf_we, rf_re}, 0);

        // R2 R3: single write then read back
        w0 = we_cnt; t0 = wait_cnt;
        write_burst(8'h3C, 1);
        check(mem[8'h3C] == exp_mem[8'h3C], "R3", mem[8'h3C], exp_mem[8'h3C]);
        check(we_cnt - w0 == 1, "R3", we_cnt - w0, 1);
        check(wait_cnt - t0 == 1, "R7 write wait", wait_cnt - t0, 1);

        r0 = re_cnt; t0 = wait_cnt;
        read_burst(8'h3C, 1, "R10");
        check(re_cnt - r0 == 2, "R5 prefetch count", re_cnt - r0, 2);
        check(wait_cnt - t0 == 4, "R7 read wait", wait_cnt - t0, 4);

        // R2: untouched location read with known pattern
        read_burst(8'h81, 2, "R2");

        // R4: burst with wrap
        write_burst(8'hFE, 3);
        check(mem[8'h00] == exp_mem[8'h00], "R4 wrap write", mem[8'h00], exp_mem[8'h00]);
        check(mem[8'hFF] == exp_mem[8'hFF], "R4", mem[8'hFF], exp_mem[8'hFF]);
        read_burst(8'hFF, 2, "R4 wrap read");

        // R1: clocking while deselected
        w0 = we_cnt; r0 = re_cnt;
        for (int i = 0; i < 24; i++) begin
            logic gg;
            clk_bit(1'($urandom), gg);
        end
        repeat (HALF) @(negedge clk);
        check(we_cnt == w0 && re_cnt == r0, "R1 strobes", we_cnt - w0 + re_cnt - r0, 0);
        check(sdo_oe == 1'b0, "R1 oe", sdo_oe, 0);
        write_burst(8'h10, 1);
        check(mem[8'h10] == exp_mem[8'h10], "R1 alignment", mem[8'h10], exp_mem[8'h10]);

        // R8: abort inside address byte
        w0 = we_cnt;
        begin_txn(1'b0);
        for (int i = 0; i < 5; i++) begin
            logic gg;
            clk_bit(1'b1, gg);
        end
        end_txn();
        check(we_cnt == w0, "R8 addr abort", we_cnt - w0, 0);
        write_burst(8'h22, 1);
        check(mem[8'h22] == exp_mem[8'h22], "R8", mem[8'h22], exp_mem[8'h22]);

        // R8: abort inside data byte
        w0 = we_cnt;
        begin_txn(1'b0);
        xfer_byte(8'h40, g);
        xfer_byte(8'hA5, g);
        exp_mem[8'h40] = 8'hA5;
        for (int i = 0; i < 3; i++) begin
            logic gg;
            clk_bit(1'b0, gg);
        end
        end_txn();
        check(we_cnt - w0 == 1, "R8 data abort", we_cnt - w0, 1);
        check(mem[8'h41] == exp_mem[8'h41], "R8 partial", mem[8'h41], exp_mem[8'h41]);
        read_burst(8'h40, 2, "R8 readback");

        // random mix
        for (int it = 0; it < 24; it++) begin
            logic [7:0] a;
            int n;
            a = 8'($urandom);
            n = 1 + int'($urandom % 4);
            if ($urandom % 2) write_burst(a, n);
            else              read_burst(a, n, "R5 random");
        end

        begin
            int bad = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
            check(bad == 0, "R3 R4 final image", bad, 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule